// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a set of external interrupt pins, by default two, and turns each one into an interrupt request towards the processor. Every pin first crosses into the system clock domain through a short synchroniser chain. Edge detection is done only on the synchronised value. A 2-bit field per channel in a sense-control register chooses how that channel raises a request: while the pin is low, on any change, on a falling edge, or on a rising edge.

In the three edge modes a detected edge sets a sticky pending flag. Software clears the flag by writing a 1 to it over the register bus, or the processor clears it with a per-channel acknowledge. In low-level mode nothing is stored, so the request lasts only while the pin stays low. A request reaches `irq_req` only when the global interrupt enable and that channel's mask bit are both set. A channel that is masked still records its edges, so the interrupt fires as soon as the mask opens.

Software reaches two registers on a simple register bus. Writes commit on the clock edge while `bus_we` is high. Read data is registered and appears one cycle after the address is presented.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the sense-control register reads 0x00, the pending-flag register reads 0x00, and `irq_req` is all zeros.
- R2: The sense-control register is at address 0x69. Bits 3..0 can be read and written. Bits 7..4 ignore writes and always read as zero: writing 0xFF reads back 0x0F, and writing 0x5A reads back 0x0A.
- R3: Bits 1..0 hold the sense mode of channel 0 and bits 3..2 hold that of channel 1. The encoding is 00 = low level, 01 = any change, 10 = falling edge, 11 = rising edge. Pending flags are at address 0x3C, with bit i belonging to channel i.
- R4: Each pin passes through a two-stage synchroniser. Suppose a pin change is first captured at clock edge k, the mode is an edge mode, and the channel is enabled. Then `irq_req` is still low after edge k+2 and rises after edge k+3.
- R5: In an edge mode, a matching edge on the synchronised pin sets that channel's pending flag, and the flag stays set. A pulse held for one clock period is enough. Edges that do not match the mode (for example a fall in rising-edge mode) set nothing.
- R6: Low-level mode is not latched. With the pin captured low at edge k, `irq_req` rises after edge k+2. With the pin captured high again at edge j, `irq_req` falls after edge j+2. The pending flag stays 0 throughout.
- R7: `irq_req[i]` is high only if both `irq_gie` and `irq_mask[i]` were high on the previous clock. An edge that arrives while the channel is gated still sets the flag, and `irq_req[i]` rises one clock after the gate opens.
- R8: A pending flag is cleared by a one-cycle `irq_ack[i]`, or by writing 1 to its bit at 0x3C. Writing 0 leaves it unchanged. If a new edge and a clear happen in the same cycle, the flag stays set.
- R9: In the first cycle in which a newly written sense mode is in force, edge detection for that channel is suppressed. An edge seen in that cycle does not set the flag.
- R10: Addresses other than 0x69 and 0x3C read as zero. Writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Registered read data for the address presented one cycle earlier |
| irq_pin | input | NUM_CH | Asynchronous external interrupt pins |
| irq_gie | input | 1 | Global interrupt enable |
| irq_mask | input | NUM_CH | Per-channel interrupt mask (1 = enabled) |
| irq_ack | input | NUM_CH | Per-channel acknowledge; clears the pending flag |
| irq_req | output | NUM_CH | Registered, gated interrupt requests |

## Verification
The bench builds the block with its defaults: two channels, a two-stage synchroniser and 8-bit address and data. This puts the channel-1 field at bits 3..2 and the reserved bits 7..4 within reach. It also fixes the exact latencies: three clocks from capture to request in edge modes and two in level mode, and the bench samples on those exact cycles. A table of pin waveforms drives every sense mode with one-cycle pulses and with non-matching edges. Directed tests then time an edge so that it lands in the very cycle a new mode takes effect, and check gating, acknowledge and write-one-to-clear.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eirq_chan.sv
module eirq_chan
  import eirq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   s_in,
  input  sense_e mode,
  input  logic   ack,
  input  logic   flag_clr,
  output logic   pend,
  output logic   raw
);
  logic   hist;
  sense_e mode_q;
  logic   rise, fall, hit, settled, set_pend;

  assign rise     = s_in & ~hist;
  assign fall     = ~s_in & hist;
  assign settled  = (mode == mode_q);

  always_comb begin
    case (mode)
      SENSE_ANY:  hit = rise | fall;
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      default:    hit = 1'b0;
    endcase
  end

  assign set_pend = hit & settled;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist   <= 1'b1;
      mode_q <= SENSE_LOW;
      pend   <= 1'b0;
    end else begin
      hist   <= s_in;
      mode_q <= mode;
      if (set_pend)            pend <= 1'b1;
      else if (ack | flag_clr) pend <= 1'b0;
    end
  end

  assign raw = pend | ((mode == SENSE_LOW) & ~s_in);

  AST_ANY_SETS: assert property (@(posedge clk) disable iff (rst)
    (mode == SENSE_ANY && $past(mode) == SENSE_ANY && s_in != $past(s_in)) |=> pend); // R5
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
    (mode == SENSE_RISE && $past(mode) == SENSE_RISE && $rose(s_in)) |=> pend); // R5
  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
    (mode == SENSE_LOW && !pend) |=> !pend); // R6
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    ((ack || flag_clr) && s_in == $past(s_in)) |=> !pend); // R8
  AST_MODE_SWITCH_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode != $past(mode) && !pend) |=> !pend); // R9
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h69,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h3C,
  localparam int MODE_W = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] pend,
  output logic [DATA_W-1:0] rdata,
  output logic [MODE_W-1:0] mode,
  output logic [NUM_CH-1:0] flag_clr
);
  logic [MODE_W-1:0] ctrl_q;
  logic              hit_ctrl, hit_flag;

  assign hit_ctrl = (addr == CTRL_ADDR);
  assign hit_flag = (addr == FLAG_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      rdata  <= '0;
    end else begin
      if (we && hit_ctrl) ctrl_q <= wdata[MODE_W-1:0];
      if (hit_ctrl)      rdata <= DATA_W'(ctrl_q);
      else if (hit_flag) rdata <= DATA_W'(pend);
      else               rdata <= '0;
    end
  end

  assign mode     = ctrl_q;
  assign flag_clr = (we && hit_flag) ? wdata[NUM_CH-1:0] : '0;

  generate
    if (MODE_W < DATA_W) begin : g_rsvd
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata[DATA_W-1:MODE_W];
      AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W-1:MODE_W] == '0); // R2
    end
  endgenerate

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(we && hit_ctrl) |=> ctrl_q == $past(ctrl_q)); // R10
  AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!hit_ctrl && !hit_flag) |=> rdata == '0); // R10
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eirq_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h69,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] irq_pin,
  input  logic              irq_gie,
  input  logic [NUM_CH-1:0] irq_mask,
  input  logic [NUM_CH-1:0] irq_ack,
  output logic [NUM_CH-1:0] irq_req
);
  localparam int MODE_W = 2 * NUM_CH;

  logic [MODE_W-1:0] mode_bits;
  logic [NUM_CH-1:0] pend, raw, flag_clr, pin_s;

  eirq_regs #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTRL_ADDR(CTRL_ADDR), .FLAG_ADDR(FLAG_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .pend(pend), .rdata(bus_rdata), .mode(mode_bits), .flag_clr(flag_clr)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      eirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(irq_pin[i]), .q(pin_s[i])
      );
      eirq_chan u_chan (
        .clk(clk), .rst(rst), .s_in(pin_s[i]),
        .mode(sense_e'(mode_bits[2*i +: 2])),
        .ack(irq_ack[i]), .flag_clr(flag_clr[i]),
        .pend(pend[i]), .raw(raw[i])
      );
      AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_req[i] |-> $past(irq_gie && irq_mask[i])); // R7
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_req <= '0;
    else     irq_req <= raw & irq_mask & {NUM_CH{irq_gie}};
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> irq_req == '0); // R1
endmodule

// File: tb/tb_ext_irq_sense.sv
module tb_ext_irq_sense;
  localparam logic [7:0] A_CTRL = 8'h69;
  localparam logic [7:0] A_FLAG = 8'h3C;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [1:0] irq_pin = 2'b11;
  logic       irq_gie = 1'b0;
  logic [1:0] irq_mask = 2'b00;
  logic [1:0] irq_ack = 2'b00;
  logic [1:0] irq_req;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] rv;

  ext_irq_sense dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pin(irq_pin),
    .irq_gie(irq_gie), .irq_mask(irq_mask), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  always #2.5 clk = ~clk;

  // {mode[1:0], pin sequence [3:0] (bit3 first), expected ch0 flag}
  localparam int NV = 10;
  localparam logic [6:0] VEC [NV] = '{
    7'b11_0100_1, 7'b11_1000_0, 7'b10_1000_1, 7'b10_0111_0, 7'b01_0111_1,
    7'b01_1000_1, 7'b01_0000_0, 7'b11_0000_0, 7'b10_1011_1, 7'b00_0000_0
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    chk("R1 irq_req", {6'b0, irq_req}, 8'h00);
    rd(A_CTRL, rv); chk("R1 ctrl", rv, 8'h00);
    rd(A_FLAG, rv); chk("R1 flags", rv, 8'h00);

    // table walk on channel 0, gated off
    for (int v = 0; v < NV; v++) begin
      irq_pin[0] = VEC[v][4];
      tick(5);
      wr(A_CTRL, {6'b0, VEC[v][6:5]});
      tick(3);
      wr(A_FLAG, 8'h03);
      tick(2);
      for (int b = 2; b >= 0; b--) begin
        irq_pin[0] = VEC[v][1+b];
        tick(1);
      end
      tick(5);
      rd(A_FLAG, rv);
      chk($sformatf("R5 vector %0d", v), rv, {7'b0, VEC[v][0]});
    end

    // R4 latency, falling edge
    irq_pin[0] = 1'b1; tick(5);
    wr(A_CTRL, 8'h02); wr(A_FLAG, 8'h03);
    irq_gie = 1'b1; irq_mask = 2'b01;
    tick(3);
    irq_pin[0] = 1'b0;
    tick(3); chk("R4 req low after k+2", {6'b0, irq_req}, 8'h00);
    tick(1); chk("R4 req high after k+3", {6'b0, irq_req}, 8'h01);

    // R8 acknowledge
    irq_ack = 2'b01; tick(1); irq_ack = 2'b00;
    tick(1); chk("R8 req after ack", {6'b0, irq_req}, 8'h00);
    rd(A_FLAG, rv); chk("R8 flag after ack", rv, 8'h00);

    // R7 gating
    irq_gie = 1'b0;
    irq_pin[0] = 1'b1; tick(5);
    irq_pin[0] = 1'b0; tick(5);
    chk("R7 req gated by gie", {6'b0, irq_req}, 8'h00);
    rd(A_FLAG, rv); chk("R7 flag while gated", rv, 8'h01);
    irq_gie = 1'b1; tick(1);
    chk("R7 req after gie", {6'b0, irq_req}, 8'h01);
    irq_mask = 2'b00; tick(1);
    chk("R7 req gated by mask", {6'b0, irq_req}, 8'h00);
    irq_mask = 2'b01;

    // R8 write-one-to-clear
    wr(A_FLAG, 8'h00); rd(A_FLAG, rv); chk("R8 write 0 keeps flag", rv, 8'h01);
    wr(A_FLAG, 8'h01); rd(A_FLAG, rv); chk("R8 write 1 clears flag", rv, 8'h00);
    tick(1); chk("R8 req after w1c", {6'b0, irq_req}, 8'h00);

    // R6 level mode
    irq_pin[0] = 1'b1; tick(5);
    wr(A_CTRL, 8'h00); wr(A_FLAG, 8'h03); tick(2);
    irq_pin[0] = 1'b0;
    tick(2); chk("R6 req low after k+1", {6'b0, irq_req}, 8'h00);
    tick(1); chk("R6 req high after k+2", {6'b0, irq_req}, 8'h01);
    irq_pin[0] = 1'b1;
    tick(2); chk("R6 req held after j+1", {6'b0, irq_req}, 8'h01);
    tick(1); chk("R6 req drops after j+2", {6'b0, irq_req}, 8'h00);
    rd(A_FLAG, rv); chk("R6 no flag in level mode", rv, 8'h00);

    // R3 channel 1 field
    wr(A_CTRL, 8'h0C); irq_mask = 2'b10;
    irq_pin[1] = 1'b0; tick(5);
    wr(A_FLAG, 8'h03);
    irq_pin[1] = 1'b1; tick(5);
    rd(A_FLAG, rv); chk("R3 ch1 rising flag", rv, 8'h02);
    chk("R3 ch1 request", {6'b0, irq_req}, 8'h02);

    // R2 register bits
    wr(A_CTRL, 8'hFF); rd(A_CTRL, rv); chk("R2 reserved read zero", rv, 8'h0F);
    wr(A_CTRL, 8'h5A); rd(A_CTRL, rv); chk("R2 pattern", rv, 8'h0A);
    wr(A_CTRL, 8'h00); wr(A_FLAG, 8'h03);

    // R10 other addresses
    wr(8'h00, 8'hFF); rd(8'h00, rv); chk("R10 other addr reads 0", rv, 8'h00);
    rd(A_CTRL, rv); chk("R10 ctrl untouched", rv, 8'h00);

    // R9 edge in the first cycle of a new mode is dropped
    irq_mask = 2'b01;
    wr(A_CTRL, 8'h02);
    irq_pin[0] = 1'b0; tick(5);
    wr(A_FLAG, 8'h03); tick(2);
    irq_pin[0] = 1'b1;
    wr(A_CTRL, 8'h03);
    tick(3);
    rd(A_FLAG, rv); chk("R9 suppressed edge", rv, 8'h00);
    irq_pin[0] = 1'b0; tick(5);
    irq_pin[0] = 1'b1; tick(5);
    rd(A_FLAG, rv); chk("R9 new mode active", rv, 8'h01);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule